// File: doc/BRIEF.md
# Slot Access Bridge

The bridge sits between a host register port and five mezzanine I/O module slots. A host request carries an address, a size (8, 16 or 32 bits), a direction and write data. The bridge decodes the address into a slot number and one of four per-slot spaces: identification, I/O, memory or interrupt-select. It then runs the access on a shared 16-bit module bus. A per-slot strobe stays high until that slot acknowledges.

A 32-bit host access becomes two 16-bit module cycles, low half first. The two cycles are separated by one idle cycle. The host sees a single completion with the assembled word.

Only one module cycle is in flight at any time. A slot that stays silent for 256 cycles ends the whole access with a timeout. A timeout returns all ones and sets a sticky status flag. Byte lanes that the module leaves undriven read back as ones. Addresses that match no slot or space complete at once without any module cycle.

Top module: `slot_bridge`

## Requirements
- R1: Decode. If host_addr[26]=1, the access goes to memory space (mod_space code 2), with slot host_addr[25:23] and byte offset host_addr[22:0]. Otherwise the slot is host_addr[11:9] and host_addr[8:7] picks the space: 0 selects ID (code 0, offset host_addr[5:0]), 1 selects I/O (code 1, offset host_addr[6:0]) and 2 selects interrupt-select (code 3, offset host_addr[6:0]).
- R2: An access is unmapped when the slot is 5 or more, when host_addr[8:7]=3 in the control region, or when host_size=3. An unmapped access raises no module strobe. It completes on the first edge, returns host_rdata all ones and leaves tmo_status unchanged.
- R3: Byte lanes follow host_size. host_size 0 is a byte access: mod_be=01 for an even offset and 10 for an odd one, the write byte is host_wdata[7:0] copied onto both lanes, and a read returns the selected lane zero-extended. host_size 1 is a halfword access: mod_be=11, mod_addr=offset[22:1], and a read returns {16'h0, lane data}.
- R4: host_size 2 runs two module cycles. The low half (host_wdata[15:0]) goes first at halfword address {offset[22:2],0}. The high half (host_wdata[31:16]) follows at {offset[22:2],1}, after exactly one cycle with no strobe. A read returns {high, low}.
- R5: At most one bit of mod_sel is set. While a strobe waits for its acknowledge, mod_sel, mod_space, mod_addr, mod_we, mod_be and mod_wdata hold steady. Acknowledges from slots that are not selected are ignored.
- R6: host_ready pulses for one cycle when the access ends. Counting the request edge as 1, the completion latency is 1 plus L per module cycle answered on its L-th strobe cycle, plus 1 for the gap of a split access.
- R7: A strobe that has been high for 256 cycles without an acknowledge ends the whole access. The remaining halves are not issued, host_rdata is all ones, and tmo_status is set and stays set until reset.
- R8: On reads, each mod_rdata lane whose mod_drive bit is 0 is taken as 8'hFF.
- R9: After reset, mod_sel=0, host_ready=0 and tmo_status=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present, held until host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unmapped |
| host_addr | input | 27 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result, valid with host_ready |
| tmo_status | output | 1 | Sticky access-timeout flag |
| mod_sel | output | 5 | Per-slot cycle strobe |
| mod_space | output | 2 | Space code: 0 ID, 1 I/O, 2 memory, 3 interrupt-select |
| mod_addr | output | 22 | Module halfword address |
| mod_be | output | 2 | Byte-lane enables, bit 1 = bits 15:8 |
| mod_we | output | 1 | Module write |
| mod_wdata | output | 16 | Module write data |
| mod_rdata | input | 16 | Module read data |
| mod_drive | input | 2 | Lanes actually driven by the module |
| mod_ack | input | 5 | Per-slot acknowledge |

## Verification
The embedded properties check these points on every cycle: the strobe is one-hot or idle, strobe fields hold steady until an acknowledge, the idle gap separates the halves of a split access, the completion pulse lasts one cycle, the timeout status is sticky, and a timeout finishes with all ones. Other behaviour can only be shown by the bench scenarios, which compare against a behavioural model. These cover address decoding into slot, space and offset, lane selection and data placement, assembly of split reads, pull-up substitution, the exact completion latency, the handling of unmapped requests, and a timeout that hits only the second half of a split access.

// File: rtl/sab_pkg.sv
package sab_pkg;
    localparam int HADDR_W = 27;
    localparam int MOFF_W  = 23;
    localparam int HWA_W   = MOFF_W - 1;
    localparam int SLOT_W  = 3;
    localparam int DATA_W  = 32;
    localparam int MDATA_W = 16;

    typedef enum logic [1:0] {SP_ID = 2'd0, SP_IO = 2'd1, SP_MEM = 2'd2, SP_INT = 2'd3} space_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} size_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP, ST_DONE} state_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [MOFF_W-1:0] off;
    } dec_t;

    function automatic logic [MOFF_W-1:0] space_mask(space_e s);
        case (s)
            SP_ID:   return MOFF_W'(8'h3F);
            SP_MEM:  return '1;
            default: return MOFF_W'(8'h7F);
        endcase
    endfunction
endpackage

// File: rtl/sab_decode.sv
module sab_decode
    import sab_pkg::*;
#(
    parameter int NSLOT = 5
) (
    input  logic [HADDR_W-1:0] addr,
    input  size_e              size,
    output dec_t               dec
);
    logic   miss;
    space_e sp;

    always_comb begin
        miss = 1'b0;
        if (addr[HADDR_W-1]) begin
            sp       = SP_MEM;
            dec.slot = addr[MOFF_W+SLOT_W-1:MOFF_W];
            dec.off  = addr[MOFF_W-1:0];
        end else begin
            dec.slot = addr[11:9];
            case (addr[8:7])
                2'd0:    sp = SP_ID;
                2'd1:    sp = SP_IO;
                2'd2:    sp = SP_INT;
                default: begin sp = SP_IO; miss = 1'b1; end
            endcase
            dec.off = MOFF_W'(addr[6:0]) & space_mask(sp);
        end
        dec.space = sp;
        dec.hit   = !miss && (int'(dec.slot) < NSLOT) && (size != SZ_BAD);
    end
endmodule

// File: rtl/sab_lanes.sv
module sab_lanes
    import sab_pkg::*;
(
    input  size_e               size,
    input  logic                addr0,
    input  logic                half,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [MDATA_W-1:0]  mod_rdata,
    input  logic [1:0]          mod_drive,
    output logic [1:0]          be,
    output logic [MDATA_W-1:0]  lane_wdata,
    output logic [MDATA_W-1:0]  rd16
);
    always_comb begin
        case (size)
            SZ_BYTE: begin
                be         = addr0 ? 2'b10 : 2'b01;
                lane_wdata = {wdata[7:0], wdata[7:0]};
            end
            SZ_HALF: begin
                be         = 2'b11;
                lane_wdata = wdata[15:0];
            end
            default: begin
                be         = 2'b11;
                lane_wdata = half ? wdata[31:16] : wdata[15:0];
            end
        endcase
    end

    // Undriven lanes are pulled high on the module bus
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign rd16[8*g +: 8] = mod_drive[g] ? mod_rdata[8*g +: 8] : 8'hFF;
    end
endmodule

// File: rtl/sab_engine.sv
module sab_engine
    import sab_pkg::*;
#(
    parameter int NSLOT      = 5,
    parameter int TMO_CYCLES = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_valid,
    input  logic                host_write,
    input  size_e               host_size,
    input  logic [DATA_W-1:0]   host_wdata,
    input  dec_t                dec,
    output logic                host_ready,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                tmo_status,
    output logic [NSLOT-1:0]    mod_sel,
    output logic [1:0]          mod_space,
    output logic [HWA_W-1:0]    mod_addr,
    output logic                mod_we,
    output size_e               cur_size,
    output logic                cur_addr0,
    output logic                cur_half,
    output logic [DATA_W-1:0]   cur_wdata,
    input  logic [MDATA_W-1:0]  rd16,
    input  logic [NSLOT-1:0]    mod_ack
);
    localparam int CNT_W = $clog2(TMO_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    state_e             st;
    logic [SLOT_W-1:0]  r_slot;
    space_e             r_space;
    logic [MOFF_W-1:0]  r_off;
    size_e              r_size;
    logic               r_we;
    logic [DATA_W-1:0]  r_wdata;
    logic               half;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W-1:0]  rbuf;
    logic               tmo_q;
    logic               ack_hit, tmo_hit, is_word;

    assign mod_sel  = (st == ST_RUN) ? ({{(NSLOT-1){1'b0}}, 1'b1} << r_slot) : '0;
    assign ack_hit  = |(mod_sel & mod_ack);
    assign tmo_hit  = (st == ST_RUN) && !ack_hit && (cnt == CNT_LAST);
    assign is_word  = (r_size == SZ_WORD);
    assign mod_addr = is_word ? {r_off[MOFF_W-1:2], half} : r_off[MOFF_W-1:1];
    assign mod_space  = r_space;
    assign mod_we     = r_we;
    assign cur_size   = r_size;
    assign cur_addr0  = r_off[0];
    assign cur_half   = half;
    assign cur_wdata  = r_wdata;
    assign host_ready = (st == ST_DONE);
    assign host_rdata = rbuf;
    assign tmo_status = tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            r_slot  <= '0;
            r_space <= SP_ID;
            r_off   <= '0;
            r_size  <= SZ_BYTE;
            r_we    <= 1'b0;
            r_wdata <= '0;
            half    <= 1'b0;
            cnt     <= '0;
            rbuf    <= '0;
            tmo_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (host_valid) begin
                    r_slot  <= dec.slot;
                    r_space <= dec.space;
                    r_off   <= dec.off;
                    r_size  <= host_size;
                    r_we    <= host_write;
                    r_wdata <= host_wdata;
                    half    <= 1'b0;
                    cnt     <= '0;
                    rbuf    <= dec.hit ? '0 : '1;
                    st      <= dec.hit ? ST_RUN : ST_DONE;
                end
                ST_RUN: begin
                    if (ack_hit) begin
                        cnt <= '0;
                        if (!r_we) begin
                            case (r_size)
                                SZ_BYTE: rbuf <= {24'h0, r_off[0] ? rd16[15:8] : rd16[7:0]};
                                SZ_HALF: rbuf <= {16'h0, rd16};
                                default: if (half) rbuf[31:16] <= rd16;
                                         else      rbuf[15:0]  <= rd16;
                            endcase
                        end
                        if (is_word && !half) begin
                            half <= 1'b1;
                            st   <= ST_GAP;
                        end else begin
                            st <= ST_DONE;
                        end
                    end else if (tmo_hit) begin
                        rbuf  <= '1;
                        tmo_q <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP:  st <= ST_RUN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mod_sel));
    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_sel != '0 && !ack_hit && !tmo_hit) |=> ($stable(mod_sel) && $stable(mod_addr) && $stable(mod_we) && $stable(mod_space)));
    // R4
    split_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && is_word && !half) |=> (mod_sel == '0 && !host_ready));
    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst) host_ready |=> !host_ready);
    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst) tmo_status |=> tmo_status);
    // R7
    tmo_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_sel != '0 && !ack_hit && cnt == CNT_LAST) |=> (host_ready && host_rdata == '1 && tmo_status));
endmodule

// File: rtl/slot_bridge.sv
module slot_bridge
    import sab_pkg::*;
#(
    parameter int NSLOT      = 5,
    parameter int TMO_CYCLES = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_valid,
    output logic                host_ready,
    input  logic                host_write,
    input  logic [1:0]          host_size,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                tmo_status,
    output logic [NSLOT-1:0]    mod_sel,
    output logic [1:0]          mod_space,
    output logic [HWA_W-1:0]    mod_addr,
    output logic [1:0]          mod_be,
    output logic                mod_we,
    output logic [MDATA_W-1:0]  mod_wdata,
    input  logic [MDATA_W-1:0]  mod_rdata,
    input  logic [1:0]          mod_drive,
    input  logic [NSLOT-1:0]    mod_ack
);
    dec_t               dec;
    size_e              cur_size;
    logic               cur_addr0, cur_half;
    logic [DATA_W-1:0]  cur_wdata;
    logic [MDATA_W-1:0] rd16;

    sab_decode #(.NSLOT(NSLOT)) u_dec (
        .addr (host_addr),
        .size (size_e'(host_size)),
        .dec  (dec)
    );

    sab_engine #(.NSLOT(NSLOT), .TMO_CYCLES(TMO_CYCLES)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_size  (size_e'(host_size)),
        .host_wdata (host_wdata),
        .dec        (dec),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .tmo_status (tmo_status),
        .mod_sel    (mod_sel),
        .mod_space  (mod_space),
        .mod_addr   (mod_addr),
        .mod_we     (mod_we),
        .cur_size   (cur_size),
        .cur_addr0  (cur_addr0),
        .cur_half   (cur_half),
        .cur_wdata  (cur_wdata),
        .rd16       (rd16),
        .mod_ack    (mod_ack)
    );

    sab_lanes u_lanes (
        .size       (cur_size),
        .addr0      (cur_addr0),
        .half       (cur_half),
        .wdata      (cur_wdata),
        .mod_rdata  (mod_rdata),
        .mod_drive  (mod_drive),
        .be         (mod_be),
        .lane_wdata (mod_wdata),
        .rd16       (rd16)
    );
endmodule

// File: tb/slot_bridge_test.sv
module slot_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [26:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, tmo_status, mod_we;
    logic [31:0] host_rdata;
    logic [4:0]  mod_sel, mod_ack = '0;
    logic [1:0]  mod_space, mod_be, mod_drive = 2'b11;
    logic [21:0] mod_addr;
    logic [15:0] mod_wdata, mod_rdata = '0;

    slot_bridge uut (.*);

    always #2 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    int lat_cfg [5];
    int quota = -1;
    logic [4:0] rogue = '0;
    logic [45:0] exp_q [$];
    bit exp_tmo = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [45:0] act, input logic [45:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int s, input int sp, input logic [21:0] ha);
        return 16'((s << 13) ^ (sp << 11) ^ int'(ha[10:0])) ^ 16'h5A3C;
    endfunction

    // behavioural module responder, compared against the expected-cycle queue
    bit prev_on = 1'b0, armed = 1'b0;
    int hi = 0, cur_s = 0;
    always @(negedge clk) begin
        logic [4:0] av;
        av = '0;
        if (!rst && mod_sel != '0) begin
            chk($onehot0(mod_sel), "R5 onehot", 46'(mod_sel), 46'(0));
            for (int i = 0; i < 5; i++) if (mod_sel[i]) cur_s = i;
            if (!prev_on) begin
                hi = 1;
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected module cycle", 46'(mod_addr), 46'(0));
                else begin
                    logic [45:0] a, e;
                    e = exp_q.pop_front();
                    a = {3'(cur_s), mod_space, mod_addr, mod_be, mod_we, mod_we ? mod_wdata : 16'h0};
                    chk(a == e, "R1/R3/R4 module cycle fields", a, e);
                end
                armed = (lat_cfg[cur_s] > 0) && (quota != 0);
            end else hi++;
            if (armed && hi == lat_cfg[cur_s]) begin
                av = mod_sel;
                if (quota > 0) quota--;
            end
            begin
                logic [15:0] p;
                p = pat(cur_s, int'(mod_space), mod_addr);
                mod_rdata = {mod_drive[1] ? p[15:8] : 8'h00, mod_drive[0] ? p[7:0] : 8'h00};
            end
            prev_on = 1'b1;
        end else prev_on = 1'b0;
        mod_ack = av | (rogue & ~mod_sel);
    end

    function automatic logic [26:0] ctl(input int s, input int code, input int off);
        return 27'((s << 9) | (code << 7) | (off & 127));
    endfunction
    function automatic logic [26:0] mem(input int s, input int off);
        return 27'((1 << 26) | (s << 23) | (off & 24'h7FFFFF));
    endfunction

    task automatic acc(input bit we, input int sz, input logic [26:0] a, input logic [31:0] wd, input string req);
        int s, sp, off, nh, exp_lat, mq, cnt;
        bit hit;
        logic [31:0] exp_rd;
        if (a[26]) begin s = int'(a[25:23]); sp = 2; off = int'(a[22:0]); end
        else begin
            s = int'(a[11:9]);
            case (int'(a[8:7]))
                0: begin sp = 0; off = int'(a[5:0]); end
                1: begin sp = 1; off = int'(a[6:0]); end
                2: begin sp = 3; off = int'(a[6:0]); end
                default: begin sp = -1; off = 0; end
            endcase
        end
        hit = (s < 5) && (sp >= 0) && (sz != 3);
        exp_lat = 1;
        exp_rd = hit ? 32'h0 : 32'hFFFF_FFFF;
        mq = quota;
        if (hit) begin
            nh = (sz == 2) ? 2 : 1;
            for (int h = 0; h < nh; h++) begin
                logic [21:0] ha; logic [1:0] be; logic [15:0] w16, r16, p;
                ha  = (sz == 2) ? 22'(((off >> 2) << 1) + h) : 22'(off >> 1);
                be  = (sz == 0) ? ((off & 1) ? 2'b10 : 2'b01) : 2'b11;
                w16 = (sz == 0) ? {wd[7:0], wd[7:0]} : (sz == 1 ? wd[15:0] : (h == 1 ? wd[31:16] : wd[15:0]));
                exp_q.push_back({3'(s), 2'(sp), ha, be, we, we ? w16 : 16'h0});
                if (lat_cfg[s] == 0 || mq == 0) begin
                    exp_lat += 256; exp_rd = 32'hFFFF_FFFF; exp_tmo = 1'b1;
                    break;
                end
                if (mq > 0) mq--;
                exp_lat += lat_cfg[s] + ((h == 0 && nh == 2) ? 1 : 0);
                p = pat(s, sp, ha);
                r16 = {mod_drive[1] ? p[15:8] : 8'hFF, mod_drive[0] ? p[7:0] : 8'hFF};
                if (!we) begin
                    if (sz == 0) exp_rd = {24'h0, (off & 1) ? r16[15:8] : r16[7:0]};
                    else if (sz == 1) exp_rd = {16'h0, r16};
                    else if (h == 0) exp_rd[15:0] = r16;
                    else exp_rd[31:16] = r16;
                end
            end
        end
        @(negedge clk);
        host_valid = 1'b1; host_write = we; host_size = 2'(sz); host_addr = a; host_wdata = wd;
        cnt = 0;
        do begin
            @(posedge clk); cnt++;
            @(negedge clk);
        end while (!host_ready && cnt < 2000);
        host_valid = 1'b0;
        chk(cnt == exp_lat, {req, " R6 latency"}, 46'(cnt), 46'(exp_lat));
        chk(host_rdata == exp_rd, {req, " rdata"}, 46'(host_rdata), 46'(exp_rd));
        chk(tmo_status == exp_tmo, {req, " R7 status"}, 46'(tmo_status), 46'(exp_tmo));
        chk(exp_q.size() == 0, {req, " R5 cycle count"}, 46'(exp_q.size()), 46'(0));
        exp_q.delete();
        @(negedge clk);
        chk(!host_ready, {req, " R6 single pulse"}, 46'(host_ready), 46'(0));
    endtask

    initial begin
        for (int i = 0; i < 5; i++) lat_cfg[i] = i + 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(mod_sel == '0 && !host_ready && !tmo_status, "R9 reset state",
            46'({mod_sel, host_ready, tmo_status}), 46'(0));
        acc(1'b0, 1, ctl(0, 0, 7'h12), 32'h0, "R1 R3 id halfword read");
        acc(1'b0, 0, ctl(2, 1, 7'h45), 32'h0, "R3 io odd byte read");
        acc(1'b1, 0, ctl(4, 2, 7'h10), 32'h0000_00C7, "R3 int even byte write");
        acc(1'b1, 1, ctl(1, 1, 7'h21), 32'h0000_BEEF, "R3 io halfword write odd addr");
        acc(1'b0, 0, ctl(3, 0, 7'h5B), 32'h0, "R1 id offset alias");
        acc(1'b0, 2, mem(1, 24'h123457), 32'h0, "R4 mem word read");
        acc(1'b1, 2, mem(3, 24'h7FFFFC), 32'hCAFE_F00D, "R4 mem word write");
        mod_drive = 2'b01;
        acc(1'b0, 1, ctl(2, 1, 7'h30), 32'h0, "R8 upper lane undriven");
        mod_drive = 2'b10;
        acc(1'b0, 2, mem(0, 24'h40), 32'h0, "R8 lower lane undriven word");
        mod_drive = 2'b11;
        acc(1'b0, 1, ctl(6, 0, 0), 32'h0, "R2 slot 6");
        acc(1'b0, 1, ctl(1, 3, 0), 32'h0, "R2 space code 3");
        acc(1'b1, 3, ctl(1, 1, 0), 32'h1234, "R2 size 3");
        rogue = 5'b11111;
        lat_cfg[2] = 4;
        acc(1'b0, 1, ctl(2, 1, 7'h08), 32'h0, "R5 foreign acks ignored");
        rogue = '0;
        lat_cfg[2] = 0;
        acc(1'b0, 1, ctl(2, 1, 7'h08), 32'h0, "R7 timeout halfword");
        lat_cfg[2] = 3;
        quota = 1;
        acc(1'b0, 2, mem(0, 24'h100), 32'h0, "R7 timeout second half");
        quota = -1;
        acc(1'b0, 1, mem(4, 24'h2222), 32'h0, "R7 sticky after recovery");
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule